// File: doc/BRIEF.md
# BCD Seven-Segment Latch-Decoder with Blanking

This block stores a four-bit decimal code in a clock-enabled register and turns the stored value into drive levels for the seven segments of one display digit. A load-enable input chooses between two behaviours. While it is high, the register picks up a new code on each clock edge. While it is low, the register keeps its value, so the digit stays steady even when the code bus changes. Codes above nine never light a segment.

Two separate mechanisms turn the digit off. A forced-blank input turns off every segment. A ripple-blank pair suppresses zeroes that carry no meaning. When the incoming ripple flag is set and the stored code is zero, the digit goes dark. The block also raises its outgoing ripple flag, and that flag can feed the incoming ripple flag of the next digit in a chain.

For leading-zero suppression, tie the most significant digit's incoming flag high and pass the flag from each digit to the next less significant one. For trailing-zero suppression, run the chain the other way. A phase input inverts all seven outputs. Hold it low for common-cathode LEDs and high for common-anode LEDs. For a liquid-crystal panel, apply the same square wave that drives the backplane.

The block has no state machine. The code register has two modes: it tracks the input while the load enable is high and holds its value while the load enable is low. Nothing else in the block is clocked.

Top module: `bcd7_latch_dec`

## Requirements
- R1: A synchronous active-high reset clears the stored code to 0000 at the clock edge where `rst` is sampled high. Reset takes priority over `latch_open`.
- R2: When `latch_open` is 1 at a rising clock edge, the stored code becomes `bcd_in`. The outputs show the new code from that edge on.
- R3: When `latch_open` is 0 at a rising clock edge, the stored code keeps its value. Outputs do not follow changes on `bcd_in`.
- R4: With no blanking active and phase 0, stored codes 0 to 9 drive `seg_out` as follows, where bit 0 is segment a, bit 6 is segment g, and 1 means lit. The values are 0:0x3F, 1:0x06, 2:0x5B, 3:0x4F, 4:0x66, 5:0x6D, 6:0x7D, 7:0x07, 8:0x7F and 9:0x6F.
- R5: Stored codes 10 to 15 turn all seven segments off, whatever the other inputs are.
- R6: When `blank_in` is 1, all seven segments are off, whatever the stored code or `rb_in` is.
- R7: When `rb_in` is 1 and the stored code is 0000, all segments are off. When `rb_in` is 0, code 0000 shows the digit zero.
- R8: `rb_out` equals `rb_in` AND (stored code == 0000). It is combinational and does not depend on `blank_in` or `phase`.
- R9: When `phase` is 1, each bit of `seg_out` is the inverse of the value it would have with phase 0, including the all-off pattern. `phase` takes effect in the same cycle.
- R10: In a chain where each digit's `rb_out` drives the `rb_in` of the next less significant digit, and the top digit's `rb_in` is tied to 1, every zero digit is dark up to the first nonzero digit. All digits after it show their values, including zeroes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the stored code |
| latch_open | input | 1 | 1: load `bcd_in` each edge; 0: hold the stored code |
| bcd_in | input | 4 | Decimal code to store (bit 0 is the least significant) |
| blank_in | input | 1 | Forces all segments off |
| rb_in | input | 1 | Ripple flag in; blanks a stored zero when set |
| phase | input | 1 | Inverts all segment outputs when set |
| seg_out | output | 7 | Segment drive, bit 0 = a ... bit 6 = g |
| rb_out | output | 1 | Ripple flag out to the next digit |

## Verification
All sixteen codes are loaded one after another, and each is tried with all eight combinations of forced blank, ripple flag and phase. This sweep separates the ten glyphs from one another and from the invalid codes. It shows that ripple blanking acts only on zero, that forced blanking overrides the ripple flag, and that phase inverts the blank pattern as well as the lit ones. A hold pattern changes the code bus while loading is disabled and shows the difference between a register and a pass-through. Four chained digits, loaded with codes that have zero runs of different lengths, show the difference between leading-zero suppression and blanking every zero.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
    localparam int CODE_W   = 4;
    localparam int SEG_N    = 7;
    localparam int MAX_DIG  = 9;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_N-1:0]  seg_t;

    // Segment patterns, bit 0 = a ... bit 6 = g, 1 = lit
    function automatic seg_t glyph_of(input code_t c);
        seg_t g;
        unique case (c)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7D;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h6F;
            default: g = '0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/seg_code_store.sv
module seg_code_store
    import bcd7_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  code_t d_in,
    output code_t q_out
);
    typedef enum logic {ST_HOLD, ST_TRACK} store_mode_e;
    store_mode_e mode;

    always_comb mode = load_en ? ST_TRACK : ST_HOLD;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_out <= '0;
        end else begin
            unique case (mode)
                ST_TRACK: q_out <= d_in;
                ST_HOLD:  q_out <= q_out;
                default:  q_out <= q_out;
            endcase
        end
    end
endmodule

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
    import bcd7_pkg::*;
(
    input  code_t code_in,
    output seg_t  glyph,
    output logic  is_digit,
    output logic  is_zero
);
    always_comb begin
        glyph    = glyph_of(code_in);
        is_digit = (int'(code_in) <= MAX_DIG);
        is_zero  = (code_in == '0);
    end
endmodule

// File: rtl/seg_drive_stage.sv
module seg_drive_stage
    import bcd7_pkg::*;
(
    input  seg_t glyph,
    input  logic is_digit,
    input  logic is_zero,
    input  logic force_off,
    input  logic ripple_in,
    input  logic invert,
    output seg_t seg_drv,
    output logic ripple_out
);
    logic dark;
    seg_t lit;

    always_comb begin
        ripple_out = ripple_in & is_zero;
        dark       = force_off | ~is_digit | ripple_out;
        lit        = dark ? '0 : glyph;
    end

    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
        assign seg_drv[i] = lit[i] ^ invert;
    end
endmodule

// File: rtl/bcd7_latch_dec.sv
module bcd7_latch_dec
    import bcd7_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_open,
    input  logic [CODE_W-1:0] bcd_in,
    input  logic              blank_in,
    input  logic              rb_in,
    input  logic              phase,
    output logic [SEG_N-1:0]  seg_out,
    output logic              rb_out
);
    code_t held_code;
    seg_t  glyph;
    logic  is_digit;
    logic  is_zero;

    seg_code_store u_store (
        .clk     (clk),
        .rst     (rst),
        .load_en (latch_open),
        .d_in    (bcd_in),
        .q_out   (held_code)
    );

    seg_glyph_rom u_rom (
        .code_in  (held_code),
        .glyph    (glyph),
        .is_digit (is_digit),
        .is_zero  (is_zero)
    );

    seg_drive_stage u_drive (
        .glyph      (glyph),
        .is_digit   (is_digit),
        .is_zero    (is_zero),
        .force_off  (blank_in),
        .ripple_in  (rb_in),
        .invert     (phase),
        .seg_drv    (seg_out),
        .ripple_out (rb_out)
    );
endmodule

// File: rtl/bcd7_latch_dec_chk.sv
module bcd7_latch_dec_chk
    import bcd7_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              latch_open,
    input logic [CODE_W-1:0] bcd_in,
    input logic              blank_in,
    input logic              rb_in,
    input logic              phase,
    input logic [SEG_N-1:0]  seg_out,
    input logic              rb_out,
    input logic [CODE_W-1:0] held_code
);
    AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (rst)
        latch_open |=> held_code == $past(bcd_in)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !latch_open |=> $stable(held_code)); // R3
    AST_BAD_CODE_DARK: assert property (@(posedge clk) disable iff (rst)
        (int'(held_code) > MAX_DIG) |-> seg_out == {SEG_N{phase}}); // R5
    AST_FORCE_DARK: assert property (@(posedge clk) disable iff (rst)
        blank_in |-> seg_out == {SEG_N{phase}}); // R6
    AST_RIPPLE_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
        (rb_in && held_code == '0) |-> seg_out == {SEG_N{phase}}); // R7
    AST_RIPPLE_OUT: assert property (@(posedge clk) disable iff (rst)
        rb_out == (rb_in && held_code == '0)); // R8
endmodule

bind bcd7_latch_dec bcd7_latch_dec_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .latch_open (latch_open),
    .bcd_in     (bcd_in),
    .blank_in   (blank_in),
    .rb_in      (rb_in),
    .phase      (phase),
    .seg_out    (seg_out),
    .rb_out     (rb_out),
    .held_code  (held_code)
);

// File: tb/bcd7_latch_dec_tb_top.sv
module bcd7_latch_dec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    // expected glyphs, bit 0 = a; codes 10..15 dark
    localparam logic [6:0] EXP_GLYPH [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       latch_open = 1'b0;
    logic [3:0] bcd_in = '0;
    logic       blank_in = 1'b0;
    logic       rb_in = 1'b0;
    logic       phase = 1'b0;
    logic [6:0] seg_out;
    logic       rb_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd7_latch_dec dut_i (
        .clk(clk), .rst(rst), .latch_open(latch_open), .bcd_in(bcd_in),
        .blank_in(blank_in), .rb_in(rb_in), .phase(phase),
        .seg_out(seg_out), .rb_out(rb_out)
    );

    // four-digit chain, index 3 is most significant
    logic [3:0] ch_code [4];
    logic [6:0] ch_seg  [4];
    logic       ch_rbi  [4];
    logic       ch_rbo  [4];
    logic       ch_load = 1'b0;

    for (genvar k = 0; k < 4; k++) begin : g_chain
        if (k == 3) begin : g_top
            assign ch_rbi[k] = 1'b1;
        end else begin : g_rest
            assign ch_rbi[k] = ch_rbo[k+1];
        end
        bcd7_latch_dec chain_i (
            .clk(clk), .rst(rst), .latch_open(ch_load), .bcd_in(ch_code[k]),
            .blank_in(1'b0), .rb_in(ch_rbi[k]), .phase(1'b0),
            .seg_out(ch_seg[k]), .rb_out(ch_rbo[k])
        );
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] model_seg(input int code, input bit bl, input bit rbi, input bit ph);
        logic [6:0] p;
        p = (bl || (rbi && code == 0)) ? 7'h00 : EXP_GLYPH[code];
        return ph ? ~p : p;
    endfunction

    task automatic step(input logic [3:0] code, input bit ld);
        @(negedge clk);
        bcd_in = code;
        latch_open = ld;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic load_chain(input logic [3:0] d3, input logic [3:0] d2,
                              input logic [3:0] d1, input logic [3:0] d0);
        @(negedge clk);
        ch_code[3] = d3; ch_code[2] = d2; ch_code[1] = d1; ch_code[0] = d0;
        ch_load = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        ch_load = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) ch_code[k] = '0;
    end

    initial begin
        // R1: reset wins over a load request
        bcd_in = 4'd7;
        latch_open = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R1 seg", {1'b0, seg_out}, {1'b0, 7'h3F});
        rb_in = 1'b1;
        #1;
        check("R1 rbo", {7'b0, rb_out}, 8'h01);
        rb_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // table sweep: R2 R4 R5 R6 R7 R8 R9
        for (int c = 0; c < 16; c++) begin
            step(c[3:0], 1'b1);
            for (int m = 0; m < 8; m++) begin
                blank_in = m[0];
                rb_in    = m[1];
                phase    = m[2];
                #1;
                check(c > 9 ? "R5" : (m[0] ? "R6" : (m[1] && c == 0 ? "R7" : (m[2] ? "R9" : "R4"))),
                      {1'b0, seg_out}, {1'b0, model_seg(c, m[0], m[1], m[2])});
                check("R8", {7'b0, rb_out}, {7'b0, (m[1] && c == 0)});
            end
            blank_in = 1'b0; rb_in = 1'b0; phase = 1'b0;
        end

        // R2: new code visible right after the loading edge
        step(4'd2, 1'b1);
        check("R2", {1'b0, seg_out}, {1'b0, 7'h5B});

        // R3: hold while the bus changes
        step(4'd5, 1'b1);
        step(4'd3, 1'b0);
        check("R3 hold", {1'b0, seg_out}, {1'b0, 7'h6D});
        step(4'd0, 1'b0);
        rb_in = 1'b1;
        #1;
        check("R3 hold rbo", {7'b0, rb_out}, 8'h00);
        rb_in = 1'b0;
        step(4'd8, 1'b1);
        check("R3 release", {1'b0, seg_out}, {1'b0, 7'h7F});

        // R10: leading-zero suppression across four digits
        load_chain(4'd0, 4'd0, 4'd5, 4'd0);
        check("R10 d3", {1'b0, ch_seg[3]}, 8'h00);
        check("R10 d2", {1'b0, ch_seg[2]}, 8'h00);
        check("R10 d1", {1'b0, ch_seg[1]}, {1'b0, 7'h6D});
        check("R10 d0", {1'b0, ch_seg[0]}, {1'b0, 7'h3F});
        load_chain(4'd1, 4'd0, 4'd0, 4'd3);
        check("R10 inner zero d2", {1'b0, ch_seg[2]}, {1'b0, 7'h3F});
        check("R10 inner zero d1", {1'b0, ch_seg[1]}, {1'b0, 7'h3F});
        load_chain(4'd0, 4'd0, 4'd0, 4'd0);
        check("R10 all zero", {1'b0, ch_seg[0]}, 8'h00);
        check("R10 all zero rbo", {7'b0, ch_rbo[0]}, 8'h01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < WATCHDOG; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule